// File: doc/BRIEF.md
# Two-Bank Byte-Addressed GPIO Port

This block is a general-purpose I/O port reached over a small byte-wide register bus. Its pins are divided into two banks, one for each supply domain: a core bank and a resume bank. Each bank holds three per-pin registers. The enable register claims a pin for GPIO use. The direction register selects input or output. The level register holds the output value, and reading it returns what the pins show. Software reads and writes these registers one byte at a time through an address, a write strobe with write data, and a read strobe with registered read data.

Every pin presents a tristate-style triple to the pad ring: a drive value, an output enable and the sampled pad input. A pin drives only when it is enabled and set as an output. The level storage accepts a write only while its pin is an output, so an output value cannot be staged before the direction changes. Parameters set the size of each bank and which pins come out of reset already enabled.

Top module: `gpio_dual_bank`

## Requirements
- R1: After a synchronous reset, every enable bit equals its bank's reset mask, every direction bit is 1, all level storage is 0, pin_oe and pin_out are all 0 and rd_data is 0x00.
- R2: In each bank, enable sits at byte offset 0x00, direction at 0x04 and level at 0x08. Pin n of a bank is at byte offset reg + n/8, bit n mod 8. The resume bank uses the same layout at base 0x20. On the pin vectors, core pins come first, followed by the resume pins.
- R3: Direction bit 1 makes a pin an input and 0 makes it an output. pin_oe of a pin is 1 exactly when its enable bit is 1 and its direction bit is 0.
- R4: A write to a level bit is ignored while that pin's direction bit is 1, and it is stored while the direction bit is 0. pin_out always shows the stored level.
- R5: A read of a level byte returns, for each pin, the stored level if the pin is driving (enabled and output) and pin_in otherwise.
- R6: Bits for pin positions at or beyond a bank's pin count read as 0 and ignore writes. Offsets 0x0C to 0x1F within either bank map to no register: they read 0x00, and writes to them change nothing.
- R7: rd_data is registered. It shows the addressed byte one clock after rd_stb is sampled, and it holds its value on every cycle without rd_stb.
- R8: A write takes effect on the clock edge at which wr_stb is sampled. A read sampled on that same edge returns the value from before the write.
- R9: When a pin returns from input to output, it drives the level last stored while it was an output, because writes made while it was an input were dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 6 | Byte address (bit 5 selects the resume bank) |
| wr_stb | input | 1 | Write strobe, one byte per sampled cycle |
| wr_data | input | 8 | Write data byte |
| rd_stb | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | CORE_PINS+RESUME_PINS | Sampled pad inputs |
| pin_out | output | CORE_PINS+RESUME_PINS | Drive values |
| pin_oe | output | CORE_PINS+RESUME_PINS | Output enables |

## Verification
A read and a write can be sampled on the same edge, and they can target the same byte. The read must then return the contents from before the write, while the write still lands. The bench provokes this with directed same-address read-plus-write operations on enable and level bytes. Random operations also assert both strobes together at random addresses. For each such operation, the bench computes the expected read from its model before it applies the write to the model, then compares rd_data, pin_oe and pin_out afterwards.

// File: rtl/gpio_dual_bank_pkg.sv
// Package: shared constants and types for the two-bank GPIO port.
// Assumes a 6-bit byte address with bit 5 picking the bank and four byte
// lanes per register slot, so at most 32 pins per bank.
package gpio_dual_bank_pkg;
    localparam int ADDR_W     = 6;
    localparam int LANE_W     = 2;
    localparam int SLOT_BYTES = 4;
    localparam int MAX_PINS   = SLOT_BYTES * 8;

    typedef enum logic [1:0] {
        SEL_EN   = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_LVL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              bank_hi;
        reg_sel_e          sel;
        logic [LANE_W-1:0] lane;
    } dec_t;
endpackage

// File: rtl/gpio_addr_decode.sv
// Module: splits a byte address into bank, register and byte lane.
// Assumes the package address layout: [5] bank, [4:2] slot, [1:0] lane.
// Slots 3..7 of a bank decode to SEL_NONE.
module gpio_addr_decode
    import gpio_dual_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    // Map the slot field onto a register select.
    always_comb begin
        dec.bank_hi = addr[ADDR_W-1];
        dec.lane    = addr[LANE_W-1:0];
        case (addr[ADDR_W-2:LANE_W])
            3'd0:    dec.sel = SEL_EN;
            3'd1:    dec.sel = SEL_DIR;
            3'd2:    dec.sel = SEL_LVL;
            default: dec.sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/gpio_bank.sv
// Module: one bank of NPINS pins with enable, direction and level storage.
// Assumes NPINS <= MAX_PINS. wr_en is already qualified by bank selection.
// The level bit stores only while its pin is an output. The read byte is
// combinational and is registered by the parent.
module gpio_bank
    import gpio_dual_bank_pkg::*;
#(
    parameter int               NPINS  = 8,
    parameter logic [NPINS-1:0] EN_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        wdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [7:0]        rdata
);
    logic [NPINS-1:0]    en_q, dir_q, lvl_q;
    logic [NPINS-1:0]    drive, seen;
    logic [MAX_PINS-1:0] pad;

    // Per-pin configuration storage, updated byte lane by byte lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= EN_RST;
            dir_q <= '1;
            lvl_q <= '0;
        end else if (wr_en) begin
            for (int p = 0; p < NPINS; p++) begin
                if (int'(lane) == p / 8) begin
                    case (sel)
                        SEL_EN:  en_q[p]  <= wdata[p % 8];
                        SEL_DIR: dir_q[p] <= wdata[p % 8];
                        SEL_LVL: if (!dir_q[p]) lvl_q[p] <= wdata[p % 8];
                        default: ;
                    endcase
                end
            end
        end
    end

    // A pin drives when it is claimed and set as output.
    always_comb begin
        drive = en_q & ~dir_q;
        seen  = (drive & lvl_q) | (~drive & pin_in);
    end

    // Zero-extend the selected register and pick the addressed lane.
    always_comb begin
        case (sel)
            SEL_EN:  pad = MAX_PINS'(en_q);
            SEL_DIR: pad = MAX_PINS'(dir_q);
            SEL_LVL: pad = MAX_PINS'(seen);
            default: pad = '0;
        endcase
        rdata = pad[8*int'(lane) +: 8];
    end

    assign pin_oe  = drive;
    assign pin_out = lvl_q;
endmodule

// File: rtl/gpio_dual_bank.sv
// Module: top of the two-bank GPIO port with a byte-wide register bus.
// Assumes both strobes are synchronous to clk and pin_in is already
// synchronised. Read data is registered once and is held between reads.
module gpio_dual_bank
    import gpio_dual_bank_pkg::*;
#(
    parameter int                     CORE_PINS     = 10,
    parameter int                     RESUME_PINS   = 4,
    parameter logic [CORE_PINS-1:0]   CORE_EN_RST   = 10'h07F,
    parameter logic [RESUME_PINS-1:0] RESUME_EN_RST = 4'h7
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic                               wr_stb,
    input  logic [7:0]                         wr_data,
    input  logic                               rd_stb,
    output logic [7:0]                         rd_data,
    input  logic [CORE_PINS+RESUME_PINS-1:0]   pin_in,
    output logic [CORE_PINS+RESUME_PINS-1:0]   pin_out,
    output logic [CORE_PINS+RESUME_PINS-1:0]   pin_oe
);
    dec_t       dec;
    logic       core_wr, res_wr;
    logic [7:0] core_rd, res_rd;
    logic [7:0] rd_q;

    gpio_addr_decode u_dec (
        .addr (addr),
        .dec  (dec)
    );

    // Route the write strobe to the addressed bank only.
    always_comb begin
        core_wr = wr_stb && !dec.bank_hi;
        res_wr  = wr_stb &&  dec.bank_hi;
    end

    gpio_bank #(.NPINS(CORE_PINS), .EN_RST(CORE_EN_RST)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (core_wr),
        .sel     (dec.sel),
        .lane    (dec.lane),
        .wdata   (wr_data),
        .pin_in  (pin_in[CORE_PINS-1:0]),
        .pin_out (pin_out[CORE_PINS-1:0]),
        .pin_oe  (pin_oe[CORE_PINS-1:0]),
        .rdata   (core_rd)
    );

    gpio_bank #(.NPINS(RESUME_PINS), .EN_RST(RESUME_EN_RST)) u_resume (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res_wr),
        .sel     (dec.sel),
        .lane    (dec.lane),
        .wdata   (wr_data),
        .pin_in  (pin_in[CORE_PINS +: RESUME_PINS]),
        .pin_out (pin_out[CORE_PINS +: RESUME_PINS]),
        .pin_oe  (pin_oe[CORE_PINS +: RESUME_PINS]),
        .rdata   (res_rd)
    );

    // Capture the addressed byte on a read strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= 8'h00;
        else if (rd_stb) rd_q <= dec.bank_hi ? res_rd : core_rd;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/gpio_dual_bank_chk.sv
// Checker: temporal properties on the ports of gpio_dual_bank, bound below.
// Assumes the package address layout when it recognises unmapped offsets.
module gpio_dual_bank_chk #(
    parameter int NPIN = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic [5:0]      addr,
    input logic            wr_stb,
    input logic            rd_stb,
    input logic [7:0]      rd_data,
    input logic [NPIN-1:0] pin_out,
    input logic [NPIN-1:0] pin_oe
);
    logic unmapped;
    assign unmapped = addr[4] || (addr[3:2] == 2'b11);

    // R1: reset clears drive, drive value and read data
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && rd_data == 8'h00));

    // R3: output enables change only after a write
    p_oe_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(pin_oe));

    // R4: drive values change only after a write
    p_out_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(pin_out));

    // R6: an unmapped read returns zero
    p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && unmapped) |=> (rd_data == 8'h00));

    // R7: read data is held when no read is sampled
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(.NPIN(CORE_PINS + RESUME_PINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_stb  (wr_stb),
    .rd_stb  (rd_stb),
    .rd_data (rd_data),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/sim_gpio_dual_bank.sv
module sim_gpio_dual_bank;
    localparam int CP = 10;
    localparam int RP = 4;
    localparam int NP = CP + RP;
    localparam logic [CP-1:0] CMASK = 10'h07F;
    localparam logic [RP-1:0] RMASK = 4'h7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    addr = '0;
    logic          wr_stb = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          rd_stb = 1'b0;
    logic [7:0]    rd_data;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] last_rd = 8'h00;

    // Bench model of both banks
    logic [31:0] m_en [2];
    logic [31:0] m_dir[2];
    logic [31:0] m_lvl[2];

    always #5 clk = ~clk;

    gpio_dual_bank #(.CORE_PINS(CP), .RESUME_PINS(RP),
                     .CORE_EN_RST(CMASK), .RESUME_EN_RST(RMASK)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

    function automatic int bank_n(input int b);
        return (b == 0) ? CP : RP;
    endfunction

    function automatic logic pin_of(input int b, input int p);
        return (b == 0) ? pin_in[p] : pin_in[CP + p];
    endfunction

    function automatic logic [7:0] exp_read(input logic [5:0] a);
        int b = int'(a[5]);
        logic [7:0] v = '0;
        if (a[4] || a[3:2] == 2'b11) return 8'h00;
        for (int j = 0; j < 8; j++) begin
            int p = int'(a[1:0]) * 8 + j;
            if (p < bank_n(b)) begin
                case (a[3:2])
                    2'd0: v[j] = m_en[b][p];
                    2'd1: v[j] = m_dir[b][p];
                    default: v[j] = (m_en[b][p] && !m_dir[b][p]) ? m_lvl[b][p] : pin_of(b, p);
                endcase
            end
        end
        return v;
    endfunction

    function automatic void model_write(input logic [5:0] a, input logic [7:0] d);
        int b = int'(a[5]);
        if (a[4] || a[3:2] == 2'b11) return;
        for (int j = 0; j < 8; j++) begin
            int p = int'(a[1:0]) * 8 + j;
            if (p < bank_n(b)) begin
                case (a[3:2])
                    2'd0: m_en[b][p] = d[j];
                    2'd1: m_dir[b][p] = d[j];
                    default: if (!m_dir[b][p]) m_lvl[b][p] = d[j];
                endcase
            end
        end
    endfunction

    function automatic logic [NP-1:0] exp_oe();
        logic [NP-1:0] v;
        for (int p = 0; p < NP; p++) begin
            int b = (p < CP) ? 0 : 1;
            int q = (p < CP) ? p : p - CP;
            v[p] = m_en[b][q] && !m_dir[b][q];
        end
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_out();
        logic [NP-1:0] v;
        for (int p = 0; p < NP; p++)
            v[p] = (p < CP) ? m_lvl[0][p] : m_lvl[1][p - CP];
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // One bus cycle: optional write and/or read, then port checks.
    task automatic bus_op(input logic [5:0] a, input bit w, input logic [7:0] d,
                          input bit r, input string tag);
        logic [7:0] e;
        @(negedge clk);
        addr = a; wr_stb = w; wr_data = d; rd_stb = r;
        e = r ? exp_read(a) : last_rd;
        @(posedge clk);
        if (w) model_write(a, d);
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        check(r ? tag : "R7 hold", 32'(rd_data), 32'(e));
        last_rd = e;
        check("R3 oe", 32'(pin_oe), 32'(exp_oe()));
        check("R4 out", 32'(pin_out), 32'(exp_out()));
    endtask

    initial begin : watchdog
        #2000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        m_en[0] = 32'(CMASK); m_en[1] = 32'(RMASK);
        m_dir[0] = 32'h3FF;   m_dir[1] = 32'hF;
        m_lvl[0] = '0;        m_lvl[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 oe", 32'(pin_oe), 32'h0);
        check("R1 out", 32'(pin_out), 32'h0);
        check("R1 rd", 32'(rd_data), 32'h0);
        bus_op(6'h00, 0, 0, 1, "R1 core en lo");
        bus_op(6'h01, 0, 0, 1, "R1 core en hi");
        bus_op(6'h05, 0, 0, 1, "R1 core dir hi");
        bus_op(6'h20, 0, 0, 1, "R1 resume en");
        bus_op(6'h24, 0, 0, 1, "R1 resume dir");
        // R2: layout, lanes and resume base
        bus_op(6'h01, 1, 8'h03, 0, "R2 en pins 8,9");
        bus_op(6'h05, 1, 8'h00, 1, "R2 dir pins 8,9");
        bus_op(6'h09, 1, 8'h02, 1, "R2 level pin 9");
        bus_op(6'h24, 1, 8'h00, 0, "R2 resume dir");
        bus_op(6'h28, 1, 8'h0F, 1, "R2 resume level");
        // R4: level writes ignored on inputs
        bus_op(6'h08, 1, 8'hFF, 0, "R4 ignored");
        bus_op(6'h08, 0, 0, 1, "R4 readback");
        // R9: input->output keeps old level on pin 0
        bus_op(6'h04, 1, 8'hFE, 0, "R9 to out");
        bus_op(6'h08, 1, 8'h01, 0, "R9 set 1");
        bus_op(6'h04, 1, 8'hFF, 0, "R9 to in");
        bus_op(6'h08, 1, 8'h00, 0, "R9 drop 0");
        bus_op(6'h04, 1, 8'hFE, 0, "R9 back out");
        check("R9 pin0 level", 32'(pin_out[0]), 32'h1);
        check("R9 pin0 oe", 32'(pin_oe[0]), 32'h1);
        // R6: beyond pin count and unmapped offsets
        bus_op(6'h05, 1, 8'hFF, 1, "R6 dir hi pins");
        bus_op(6'h05, 0, 0, 1, "R6 dir hi read");
        bus_op(6'h0C, 1, 8'hFF, 0, "R6 wr 0x0C");
        bus_op(6'h3F, 1, 8'hFF, 0, "R6 wr 0x3F");
        bus_op(6'h0C, 0, 0, 1, "R6 rd 0x0C");
        bus_op(6'h2D, 0, 0, 1, "R6 rd 0x2D");
        bus_op(6'h03, 0, 0, 1, "R6 rd empty lane");
        // R5: input pins read pad values
        @(negedge clk); pin_in = 14'h2A5C;
        bus_op(6'h08, 0, 0, 1, "R5 core level");
        bus_op(6'h09, 0, 0, 1, "R5 core level hi");
        bus_op(6'h28, 0, 0, 1, "R5 resume level");
        // R8: read and write on the same edge
        bus_op(6'h00, 1, 8'h0F, 1, "R8 same-edge en");
        bus_op(6'h00, 0, 0, 1, "R8 after en");
        bus_op(6'h28, 1, 8'h05, 1, "R8 same-edge level");
        // R7: hold without read
        bus_op(6'h00, 0, 0, 0, "R7");
        bus_op(6'h21, 1, 8'hFF, 0, "R7");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] a;
            int k = $urandom_range(0, 9);
            a = 6'($urandom);
            if (k < 8) a[4] = 1'b0;
            if (k < 7 && a[3:2] == 2'b11) a[3:2] = 2'($urandom_range(0, 2));
            @(negedge clk); pin_in = NP'($urandom);
            bus_op(a, 1'($urandom), 8'($urandom), 1'($urandom),
                   (a[3:2] == 2'd2) ? "R5 random" : "R2 random");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule